// File: doc/BRIEF.md
# Transmit FIFO Start Control

This block decides when the frame at the head of a transmit FIFO may be handed to the MAC. The write side reports how many bytes of the current frame are buffered so far and whether the frame's last byte has been written. In threshold mode the block fires a start strobe as soon as the buffered count is strictly above a programmable level. A frame that never gets above that level, because it is short, is released once it is fully written. In full-frame mode the level is ignored and the strobe waits for the frame to be complete.

The level comes from a 3-bit selector whose encoding is not monotonic. The four codes with the top bit clear pick large levels in steps of 64 bytes. The four codes with the top bit set pick small levels that fall in steps of 8 bytes. After one strobe the block stays quiet until the read side reports that the launched frame has been read to its end. Only then does it re-arm and take a fresh copy of the selector and the mode bit, so settings written in the middle of a frame never affect that frame.

Top module: `txq_launch_ctrl`

## Requirements
- R1: With `level_sel[2]`=0 the start level is 64 bytes for code 3'b000, 128 for 3'b001, 192 for 3'b010 and 256 for 3'b011.
- R2: With `level_sel[2]`=1 the start level is 40 bytes for code 3'b100, 32 for 3'b101, 24 for 3'b110 and 16 for 3'b111.
- R3: In threshold mode (`full_frame_mode`=0 as captured), while armed, a `wr_bytes` value strictly greater than the start level seen at a rising edge makes `tx_start` high for the following cycle. A count equal to the level does not start the frame.
- R4: While armed, `wr_eof` high at a rising edge makes `tx_start` high for the following cycle whatever `wr_bytes` is, so a frame at or below the level starts once complete.
- R5: With `full_frame_mode`=1 as captured, `level_sel` has no effect and `tx_start` rises only after an edge at which `wr_eof` was high.
- R6: `tx_start` is a single-cycle pulse, issued exactly once per frame.
- R7: After a pulse, `tx_start` stays low whatever `wr_bytes` and `wr_eof` do until `rd_eof` is seen high at a rising edge. The block then re-arms.
- R8: `level_sel` and `full_frame_mode` are captured only at a frame boundary. This is the first rising edge with `rst` low, or the edge right after the one at which `rd_eof` was accepted. Checking for a start begins on the edge after that. Changes at any other time have no effect on the current frame.
- R9: `rst` is synchronous and active high. While it is asserted, and on the first cycle after it is released, `tx_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_bytes | input | CNT_W | Bytes of the current frame written into the FIFO |
| wr_eof | input | 1 | Last byte of the current frame has been written |
| level_sel | input | 3 | Start level selector code |
| full_frame_mode | input | 1 | 1: release only complete frames; selector ignored |
| rd_eof | input | 1 | Read side has consumed the end of the launched frame |
| tx_start | output | 1 | One-cycle start strobe to the MAC |

## Verification
The bench drives each of the eight selector codes with a ramp of one byte per cycle. A design with a swapped or monotonic decode, or one that compares with greater-or-equal, would start one or more cycles off the expected cycle. It runs frames whose length equals the level exactly and frames shorter than it; these must wait for the end-of-frame flag, and a design that compares loosely would start early or never. During every frame it scrambles the selector and the mode bit, so a design that does not latch them would start at the wrong time. After each strobe it holds large counts and the end flag high, where a design that re-arms without the read-side end marker would pulse twice.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int THR_W = 9;
    localparam int N_CODES = 8;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SENT  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic       whole;
        logic [2:0] code;
    } txl_cfg_t;

    // Non-monotonic level decode: top bit clear gives 64-byte steps upward,
    // top bit set gives 8-byte steps downward from 40.
    function automatic logic [THR_W-1:0] level_of_code(input logic [2:0] c);
        logic [THR_W-1:0] r;
        if (c[2])
            r = THR_W'(40) - THR_W'({c[1:0], 3'b000});
        else
            r = THR_W'({c[1:0], 6'b000000}) + THR_W'(64);
        return r;
    endfunction

endpackage

// File: rtl/txl_cfg_latch.sv
module txl_cfg_latch
    import txl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  txl_cfg_t cfg_in,
    output txl_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

    // R8: settings stay frozen outside a frame boundary
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/txl_level_decode.sv
module txl_level_decode
    import txl_pkg::*;
(
    input  logic [2:0]       code,
    output logic [THR_W-1:0] level
);

    logic [THR_W-1:0] tab [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_tab
        assign tab[g] = level_of_code(3'(g));
    end

    assign level = tab[code];

endmodule

// File: rtl/txl_start_eval.sv
module txl_start_eval
    import txl_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  txl_cfg_t         cfg,
    input  logic [THR_W-1:0] level,
    input  logic [CNT_W-1:0] wr_bytes,
    input  logic             wr_eof,
    output logic             go
);

    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] lvl_ext;
    logic             above;

    assign cnt_ext = CMP_W'(wr_bytes);
    assign lvl_ext = CMP_W'(level);
    assign above   = cnt_ext > lvl_ext;

    always_comb begin
        if (cfg.whole)
            go = wr_eof;
        else
            go = wr_eof || above;
    end

endmodule

// File: rtl/txl_seq.sv
module txl_seq
    import txl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic rd_eof,
    output logic load,
    output logic armed,
    output logic launch
);

    seq_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_LOAD;
            launch <= 1'b0;
        end else begin
            launch <= 1'b0;
            unique case (st)
                ST_LOAD:  st <= ST_ARMED;
                ST_ARMED: if (go) begin
                    st     <= ST_SENT;
                    launch <= 1'b1;
                end
                ST_SENT:  if (rd_eof) st <= ST_LOAD;
                default:  st <= ST_LOAD;
            endcase
        end
    end

    assign load  = (st == ST_LOAD);
    assign armed = (st == ST_ARMED);

    // R6: strobe lasts one cycle
    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);

    // R7: no strobe while the launched frame is still being read
    p_quiet_sent_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SENT) |=> !launch);

    // R7: read-side end marker returns the block to a boundary
    p_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SENT && rd_eof) |=> load);

endmodule

// File: rtl/txq_launch_ctrl.sv
module txq_launch_ctrl
    import txl_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] wr_bytes,
    input  logic             wr_eof,
    input  logic [2:0]       level_sel,
    input  logic             full_frame_mode,
    input  logic             rd_eof,
    output logic             tx_start
);

    txl_cfg_t         cfg_in;
    txl_cfg_t         cfg_q;
    logic [THR_W-1:0] level;
    logic             go;
    logic             load;
    logic             armed;

    assign cfg_in.whole = full_frame_mode;
    assign cfg_in.code  = level_sel;

    txl_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    txl_level_decode u_dec (
        .code  (cfg_q.code),
        .level (level)
    );

    txl_start_eval #(.CNT_W(CNT_W)) u_eval (
        .cfg      (cfg_q),
        .level    (level),
        .wr_bytes (wr_bytes),
        .wr_eof   (wr_eof),
        .go       (go)
    );

    txl_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .rd_eof (rd_eof),
        .load   (load),
        .armed  (armed),
        .launch (tx_start)
    );

    // R3: count above the captured level while armed starts the frame
    p_thr_start_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && !cfg_q.whole && (CNT_W'(level) < wr_bytes)) |=> tx_start);

    // R4: a completely written frame starts even below the level
    p_short_eof_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && wr_eof) |=> tx_start);

    // R5: full-frame mode waits for the end flag
    p_whole_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_start && cfg_q.whole) |-> $past(wr_eof));

endmodule

// File: tb/test_txq_launch_ctrl.sv
`timescale 1ns/1ps
module test_txq_launch_ctrl;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] wr_bytes;
    logic             wr_eof;
    logic [2:0]       level_sel;
    logic             full_frame_mode;
    logic             rd_eof;
    logic             tx_start;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    txq_launch_ctrl #(.CNT_W(CNT_W)) i_txq_launch_ctrl (
        .clk             (clk),
        .rst             (rst),
        .wr_bytes        (wr_bytes),
        .wr_eof          (wr_eof),
        .level_sel       (level_sel),
        .full_frame_mode (full_frame_mode),
        .rd_eof          (rd_eof),
        .tx_start        (tx_start)
    );

    function automatic int ref_level(input int code);
        case (code)
            0: return 64;
            1: return 128;
            2: return 192;
            3: return 256;
            4: return 40;
            5: return 32;
            6: return 24;
            default: return 16;
        endcase
    endfunction

    function automatic bit ref_go(input bit whole, input int code,
                                  input int bytes, input bit eof);
        if (whole) return eof;
        return eof || (bytes > ref_level(code));
    endfunction

    task automatic check(input bit act, input bit exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One frame: boundary, byte ramp with scrambled settings, then quiet hold.
    task automatic run_frame(input int code, input bit whole, input int len,
                             input int step, input int eofdly,
                             input bit after_reset, input string req);
        int  pulses;
        int  tfull;
        int  t;
        bit  done;
        bit  exp;
        bit  eof;
        int  b;
        if (!after_reset) begin
            level_sel       = 3'(code);
            full_frame_mode = whole;
            wr_bytes        = '0;
            wr_eof          = 1'b0;
            rd_eof          = 1'b1;
            @(negedge clk);
            check(tx_start, 1'b0, "R7");
            rd_eof = 1'b0;
            @(negedge clk);
            check(tx_start, 1'b0, "R8");
        end else begin
            @(negedge clk);
            check(tx_start, 1'b0, "R9");
        end
        pulses = 0;
        tfull  = -1;
        t      = 1;
        done   = 1'b0;
        while (!done) begin
            b = t * step;
            if (b > len) b = len;
            if (b == len && tfull < 0) tfull = t;
            eof = (tfull >= 0) && (t >= tfull + eofdly);
            wr_bytes        = CNT_W'(b);
            wr_eof          = eof;
            level_sel       = 3'($urandom);   // R8: must not matter mid-frame
            full_frame_mode = 1'($urandom);
            exp = (pulses == 0) && ref_go(whole, code, b, eof);
            @(negedge clk);
            check(tx_start, exp, req);
            if (tx_start) pulses++;
            if (tfull >= 0 && t >= tfull + eofdly + 1) done = 1'b1;
            t++;
        end
        for (int k = 0; k < 3; k++) begin
            wr_bytes = '1;
            wr_eof   = (k != 1);
            @(negedge clk);
            check(tx_start, 1'b0, "R7");
            if (tx_start) pulses++;
        end
        check(pulses == 1, 1'b1, "R6");
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2718));
        rst = 1'b1;
        wr_bytes = '0;
        wr_eof = 1'b0;
        rd_eof = 1'b0;
        level_sel = 3'b000;
        full_frame_mode = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(tx_start, 1'b0, "R9");
        end
        rst = 1'b0;

        // R1: large levels, ramp one byte per cycle, must start at level+1
        run_frame(0, 1'b0, 70, 1, 2, 1'b1, "R1");
        run_frame(1, 1'b0, 134, 1, 2, 1'b0, "R1");
        run_frame(2, 1'b0, 198, 1, 2, 1'b0, "R1");
        run_frame(3, 1'b0, 262, 1, 2, 1'b0, "R1");
        // R2: small levels
        run_frame(4, 1'b0, 46, 1, 2, 1'b0, "R2");
        run_frame(5, 1'b0, 38, 1, 2, 1'b0, "R2");
        run_frame(6, 1'b0, 30, 1, 2, 1'b0, "R2");
        run_frame(7, 1'b0, 22, 1, 2, 1'b0, "R2");
        // R3: one byte above the level, strict comparison
        run_frame(4, 1'b0, 41, 1, 3, 1'b0, "R3");
        // R4: length equal to the level and below it
        run_frame(4, 1'b0, 40, 1, 3, 1'b0, "R4");
        run_frame(0, 1'b0, 20, 2, 4, 1'b0, "R4");
        run_frame(3, 1'b0, 256, 4, 1, 1'b0, "R4");
        // R5: full-frame mode with a long frame and a small selector
        run_frame(7, 1'b1, 100, 3, 4, 1'b0, "R5");
        run_frame(0, 1'b1, 30, 1, 0, 1'b0, "R5");

        // R9: reset in the middle of a frame, then restart after release
        level_sel = 3'b010;
        full_frame_mode = 1'b0;
        wr_bytes = CNT_W'(50);
        wr_eof = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check(tx_start, 1'b0, "R9");
        end
        wr_bytes = '0;
        rst = 1'b0;
        run_frame(2, 1'b0, 200, 2, 1, 1'b1, "R9");

        // R3: constrained random frames
        for (int n = 0; n < 40; n++) begin
            run_frame(int'($urandom % 8), 1'($urandom), 1 + int'($urandom % 300),
                      1 + int'($urandom % 8), int'($urandom % 6), 1'b0, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule